// File: doc/BRIEF.md
# Ethernet Multicast Hash Filter

This block decides whether a received destination MAC address passes a 64-bit logical address filter. An address arrives over a valid/ready input. The block runs a CRC-32 over the six address bytes, takes six bits of the final register as a hash, and looks up one bit of the filter with that hash. When the lookup finishes it raises a one-cycle `done` pulse together with the multicast flag, the hash, the accept decision and a one-hot mask of the filter bit that this address maps to. Software uses the mask to build a filter: it submits every wanted group address and ORs the masks together.

The CRC advances `BITS_PER_CYC` address bits per clock. The default of 1 gives a bit-serial engine of 48 cycles per address. Any divisor of 48 chains that many one-bit CRC stages in a single cycle, and 48 gives a fully unrolled single-cycle engine. Two override pins are sampled in the cycle that completes the hash: one accepts every frame, and one accepts every multicast frame. The unicast address compare is handled elsewhere, so a unicast address is accepted only through the promiscuous override.

Back-pressure: `in_ready` is high whenever the engine is idle. An address transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low until that address's `done` pulse. The result side has no back-pressure: the result ports keep their values until the next `done` pulse. `filter_map`, `promisc_en` and `allmc_en` should be held steady from acceptance to `done`.

Top module: `mcast_hash_filter`

## Requirements
- R1: `in_ready` is high when idle and low from the edge that accepts an address until its `done` pulse. While it is low, `in_valid` and `in_addr` are ignored.
- R2: `done` is high for exactly one cycle, in the cycle after the 48/`BITS_PER_CYC`-th rising edge that follows the accepting edge.
- R3: `res_mcast` equals `in_addr[0]`. `in_addr[7:0]` is the first address byte on the wire, and its bit 0 is the group bit.
- R4: The CRC register starts at all ones. It consumes `in_addr[0]`, `in_addr[1]`, … `in_addr[47]` in that order. Each step shifts the register one place towards bit 31 with a 0 entering bit 0. When the incoming bit XOR the old bit 31 is 1, the register is XORed with 0x04C11DB7.
- R5: `res_hash` = {crc[0], crc[1], crc[2], crc[3], crc[4], crc[5]}, so crc[0] is the most significant bit. It is reported for every address.
- R6: For a multicast address with both overrides off, `res_match` equals bit (hash & 7) of filter byte (hash >> 3). Byte k is `filter_map[8k+7:8k]`, so this is `filter_map[hash]`.
- R7: With `allmc_en` high, every multicast address is accepted, whatever `filter_map` holds.
- R8: With `promisc_en` high, every address, unicast or multicast, is accepted.
- R9: A unicast address with `promisc_en` low is rejected and gives an all-zero `res_setmask`.
- R10: For a multicast address, `res_setmask` has exactly one bit set, at position `res_hash`.
- R11: After reset all result ports are zero, and they change only at a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Engine idle, address can be taken |
| in_addr | input | 48 | Destination address, first byte in bits 7:0 |
| filter_map | input | 64 | Logical address filter, byte k in bits 8k+7:8k |
| promisc_en | input | 1 | Accept every frame |
| allmc_en | input | 1 | Accept every multicast frame |
| done | output | 1 | One-cycle pulse: results valid |
| res_mcast | output | 1 | Address was multicast |
| res_hash | output | 6 | Six-bit filter index |
| res_match | output | 1 | Frame accepted |
| res_setmask | output | 64 | One-hot filter bit for this address, zero for unicast |

## Verification
Directed group addresses run first. The filter is set to exactly the bit that the independently computed hash selects, and then to every bit except that one. This separates a correct index from a bit-reversed or byte-swapped one. Unicast and broadcast addresses are run with each override on and off, which shows that the override gating is kept apart from the filter lookup. A new address is offered while the engine is busy, and `in_valid` is also held high across several back-to-back transfers. Both patterns expose an engine that would take data out of turn. A run of random addresses and random filters then checks the CRC bit order and the polynomial over many hash values.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int ADDR_W = 48;
  localparam int CRC_W  = 32;
  localparam int HASH_W = 6;
  localparam int FILT_W = 1 << HASH_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;
endpackage

// File: rtl/mhf_crc_step.sv
module mhf_crc_step
  import mhf_pkg::*;
(
  input  logic [CRC_W-1:0] crc_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic fb;
  assign fb    = bit_i ^ crc_i[CRC_W-1];
  assign crc_o = {crc_i[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
endmodule

// File: rtl/mhf_hash_engine.sv
module mhf_hash_engine
  import mhf_pkg::*;
#(
  parameter int BITS_PER_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              fin,
  output logic              mc,
  output logic [CRC_W-1:0]  crc_nx
);
  localparam int NCYC = ADDR_W / BITS_PER_CYC;
  localparam int CW   = $clog2(NCYC + 1);

  logic [ADDR_W-1:0] sh;
  logic [CW-1:0]     left;
  logic [CRC_W-1:0]  crc;
  logic [CRC_W-1:0]  chain [BITS_PER_CYC+1];

  assign chain[0] = crc;

  generate
    for (genvar k = 0; k < BITS_PER_CYC; k++) begin : g_stage
      mhf_crc_step u_step (
        .crc_i (chain[k]),
        .bit_i (sh[k]),
        .crc_o (chain[k+1])
      );
    end
  endgenerate

  assign crc_nx = chain[BITS_PER_CYC];
  assign busy   = (left != '0);
  assign fin    = (left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
      crc  <= CRC_SEED;
      mc   <= 1'b0;
    end else if (start) begin
      sh   <= addr;
      left <= CW'(NCYC);
      crc  <= CRC_SEED;
      mc   <= addr[0];
    end else if (busy) begin
      sh   <= sh >> BITS_PER_CYC;
      crc  <= crc_nx;
      left <= left - CW'(1);
    end
  end
endmodule

// File: rtl/mhf_filter_lookup.sv
module mhf_filter_lookup
  import mhf_pkg::*;
(
  input  logic [CRC_W-1:0]  crc,
  input  logic              mc,
  input  logic [FILT_W-1:0] filter_map,
  input  logic              promisc_en,
  input  logic              allmc_en,
  output logic [HASH_W-1:0] hash,
  output logic              match,
  output logic [FILT_W-1:0] setmask
);
  generate
    for (genvar i = 0; i < HASH_W; i++) begin : g_rev
      assign hash[HASH_W-1-i] = crc[i];
    end
  endgenerate

  logic hit;
  assign hit     = allmc_en | filter_map[hash];
  assign match   = promisc_en | (mc & hit);
  assign setmask = mc ? (FILT_W'(1) << hash) : '0;
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int BITS_PER_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [47:0]       in_addr,
  input  logic [63:0]       filter_map,
  input  logic              promisc_en,
  input  logic              allmc_en,
  output logic              done,
  output logic              res_mcast,
  output logic [5:0]        res_hash,
  output logic              res_match,
  output logic [63:0]       res_setmask
);
  logic              busy, fin, mc, start;
  logic [CRC_W-1:0]  crc_nx;
  logic [HASH_W-1:0] hash_nx;
  logic              match_nx;
  logic [FILT_W-1:0] mask_nx;

  assign in_ready = !busy;
  assign start    = in_valid && in_ready;

  mhf_hash_engine #(.BITS_PER_CYC(BITS_PER_CYC)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .addr   (in_addr),
    .busy   (busy),
    .fin    (fin),
    .mc     (mc),
    .crc_nx (crc_nx)
  );

  mhf_filter_lookup u_lookup (
    .crc        (crc_nx),
    .mc         (mc),
    .filter_map (filter_map),
    .promisc_en (promisc_en),
    .allmc_en   (allmc_en),
    .hash       (hash_nx),
    .match      (match_nx),
    .setmask    (mask_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      res_mcast   <= 1'b0;
      res_hash    <= '0;
      res_match   <= 1'b0;
      res_setmask <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        res_mcast   <= mc;
        res_hash    <= hash_nx;
        res_match   <= match_nx;
        res_setmask <= mask_nx;
      end
    end
  end
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [47:0] in_addr,
  input logic [63:0] filter_map,
  input logic        promisc_en,
  input logic        allmc_en,
  input logic        done,
  input logic        res_mcast,
  input logic [5:0]  res_hash,
  input logic        res_match,
  input logic [63:0] res_setmask
);
  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(promisc_en)) |-> res_match);

  // R9
  unicast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_mcast && !$past(promisc_en)) |-> (!res_match && res_setmask == 64'd0));

  // R10
  setmask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(res_setmask) == (res_mcast ? 1 : 0)));

  // R10
  setmask_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_mcast) |-> res_setmask[res_hash]);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_hash) && $stable(res_match) && $stable(res_mcast)));
endmodule

bind mcast_hash_filter mhf_checker u_mhf_checker (.*);

// File: tb/test_mcast_hash_filter.sv
module test_mcast_hash_filter;
  localparam int NCYC = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_addr = '0;
  logic [63:0] filter_map = '0;
  logic        promisc_en = 1'b0;
  logic        allmc_en = 1'b0;
  logic        done, res_mcast, res_match;
  logic [5:0]  res_hash;
  logic [63:0] res_setmask;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mcast_hash_filter i_mcast_hash_filter (.*);

  function automatic int ref_hash(input logic [47:0] a);
    logic [32:0] c;
    int h;
    c = '1;
    for (int i = 0; i < 48; i++) begin
      c = {c[31:0], 1'b0};
      if (a[i] ^ c[32]) c[31:0] = c[31:0] ^ 32'h04C11DB7;
    end
    h = 0;
    for (int i = 0; i < 6; i++) h = (h << 1) + int'(c[i]);
    return h;
  endfunction

  // behavioural reference model
  bit          m_busy = 0, m_done = 0, m_mc = 0, m_match = 0;
  int          m_left = 0, m_hash = 0;
  logic [47:0] m_addr = '0;
  logic [63:0] m_mask = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_mc = 0; m_match = 0; m_hash = 0; m_mask = '0; m_left = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy  = 0;
          m_done  = 1;
          m_mc    = m_addr[0];
          m_hash  = ref_hash(m_addr);
          m_mask  = m_mc ? (64'd1 << m_hash) : 64'd0;
          m_match = promisc_en || (m_mc && (allmc_en || filter_map[m_hash]));
        end
      end else if (in_valid) begin
        m_busy = 1;
        m_left = NCYC;
        m_addr = in_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk(in_ready == !m_busy, "R1", "in_ready", 64'(in_ready), 64'(!m_busy));
      chk(done == m_done, "R2", "done", 64'(done), 64'(m_done));
      chk(res_mcast == m_mc, m_done ? "R3" : "R11", "res_mcast", 64'(res_mcast), 64'(m_mc));
      chk(int'(res_hash) == m_hash, m_done ? "R4 R5" : "R11", "res_hash", 64'(res_hash), 64'(m_hash));
      chk(res_match == m_match,
          !m_done ? "R11" : promisc_en ? "R8" : !m_mc ? "R9" : allmc_en ? "R7" : "R6",
          "res_match", 64'(res_match), 64'(m_match));
      chk(res_setmask == m_mask, m_done ? (m_mc ? "R10" : "R9") : "R11",
          "res_setmask", res_setmask, m_mask);
    end
  end

  task automatic run(input logic [47:0] a);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (NCYC + 2) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [47:0] grp, uni;
    grp = 48'h0100_005E_0001 | 48'h1;
    grp[7:0] = 8'h01;
    uni = 48'h3412_7856_AB02;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6: filter holds exactly the selected bit, then all other bits
    filter_map = 64'd1 << ref_hash(grp);
    run(grp);
    filter_map = ~(64'd1 << ref_hash(grp));
    run(grp);
    // R7: accept-all-multicast with empty filter
    filter_map = '0;
    allmc_en = 1'b1;
    run(grp);
    allmc_en = 1'b0;
    run(grp);
    // R9, R8: unicast without and with promiscuous
    filter_map = '1;
    run(uni);
    promisc_en = 1'b1;
    run(uni);
    filter_map = '0;
    run(grp);
    promisc_en = 1'b0;
    // broadcast
    filter_map = 64'd1 << ref_hash('1);
    run('1);
    // R1: new address offered while busy is ignored
    @(negedge clk);
    in_valid = 1'b1; in_addr = grp;
    @(negedge clk);
    in_addr = uni;
    repeat (10) @(negedge clk);
    in_valid = 1'b0;
    repeat (NCYC) @(negedge clk);
    // R2: valid held high for back-to-back transfers
    in_valid = 1'b1; in_addr = 48'hC0FF_EE00_1133;
    repeat (3 * (NCYC + 2)) @(negedge clk);
    in_valid = 1'b0;
    repeat (NCYC + 2) @(negedge clk);
    // random addresses and filters: R4 R5 R10
    for (int n = 0; n < 24; n++) begin
      filter_map = {$urandom(), $urandom()};
      allmc_en   = (n % 7 == 3);
      run({$urandom(), $urandom()} [47:0]);
    end
    summary();
  end
endmodule